// File: doc/BRIEF.md
# Stack and Status Register Unit

This unit keeps the stack pointer and the processor status byte of a small 8-bit accumulator processor, and it runs every bus cycle needed to move bytes, words and saved context between those registers and a stack held in memory. The instruction sequencer issues one command at a time on a valid/ready pair. The unit then performs one to three single-cycle memory accesses and raises a one-cycle `done` pulse. For pop-type commands, the popped byte or word is on `rd_data` while `done` is high.

Every stack access falls in memory page one, so the upper address byte is fixed at 0x01 and the lower byte comes from the stack pointer. The status byte has two phantom positions, bits 4 and 5. A push of the status byte always writes ones into them. A pull from the stack keeps the register's own values in those two bits and ignores what memory holds there. The memory port is synchronous: write data is taken in the request cycle, and read data comes back in the following cycle.

Top module: `stk_stat_unit`

## Requirements
- R1: After reset, `sp` is 0xFF, `status` is 0x24, `cmd_ready` is 1, and both `done` and `mem_req` are 0.
- R2: A byte push (`cmd_op` 0) writes `cmd_data[7:0]` at 0x0100+sp and then decrements sp. A byte pop (`cmd_op` 2) first increments sp, then reads 0x0100+sp and returns the byte on `rd_data[7:0]` with `rd_data[15:8]` at zero.
- R3: A word push (`cmd_op` 1) writes `cmd_data[15:8]` first and `cmd_data[7:0]` second. A word pop (`cmd_op` 3) reads the low byte first and the high byte second, and returns {high, low} on `rd_data`.
- R4: A status push (`cmd_op` 4) writes the status byte with bits 4 and 5 set to one, and leaves the register unchanged.
- R5: A status pull (`cmd_op` 5) loads bits 7..6 and 3..0 from the stack byte. Bits 5..4 keep their current values.
- R6: Return-from-interrupt (`cmd_op` 6) pulls status under the R5 rule and then pops a word (low byte, then high byte) onto `rd_data`.
- R7: Context save (`cmd_op` 7) pushes `cmd_data[15:8]`, then `cmd_data[7:0]`, then the status byte with bits 4 and 5 forced to one.
- R8: Every memory access has address bits 15..8 equal to 0x01. The stack pointer wraps modulo 256 in both directions.
- R9: `done` is high for exactly one cycle. For a command of n accesses accepted at a clock edge, `done` rises at the n-th following edge if the command only writes, and at the (n+1)-th following edge if it reads. `cmd_ready` is low from the accepting edge until that edge.
- R10: A `cmd_valid` that arrives while `cmd_ready` is low is ignored: it issues no memory access, and it changes neither the registers nor the result of the running command.
- R11: A read access samples `mem_rdata` one cycle after the request. A write access presents its data in the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | Command code (0..7, see requirements) |
| cmd_data | input | 16 | Byte or word to push; program counter for context save |
| cmd_ready | output | 1 | Unit idle, command accepted when valid |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Popped byte or word, valid with done |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, one cycle after the read request |
| sp | output | 8 | Stack pointer |
| status | output | 8 | Processor status byte |

## Verification
An error in the pointer shows on `mem_addr` at the next access, and every later push or pop lands one slot away from where it should. The bench catches this by comparing the whole stack page and `sp` after each command. A status register that disturbs its phantom bits is caught on `status` at the `done` of the pull that caused it. It is also caught on the written byte of the next status push. A sequencing error, such as a wrong byte order, a missing capture cycle or a done pulse that comes early or late, shows within the same command as a wrong `rd_data`, wrong memory contents or a wrong latency count.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [2:0] {
    OP_PUSH_B   = 3'd0,
    OP_PUSH_W   = 3'd1,
    OP_POP_B    = 3'd2,
    OP_POP_W    = 3'd3,
    OP_PUSH_ST  = 3'd4,
    OP_PULL_ST  = 3'd5,
    OP_RTI      = 3'd6,
    OP_SAVE_CTX = 3'd7
  } stk_op_e;

  // true when every access of the command is a read
  function automatic logic op_reads(input stk_op_e op);
    return (op == OP_POP_B) || (op == OP_POP_W) ||
           (op == OP_PULL_ST) || (op == OP_RTI);
  endfunction

  // number of memory accesses of the command
  function automatic logic [1:0] op_beats(input stk_op_e op);
    logic [1:0] n;
    case (op)
      OP_PUSH_W, OP_POP_W:   n = 2'd2;
      OP_RTI, OP_SAVE_CTX:   n = 2'd3;
      default:               n = 2'd1;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/stk_ptr.sv
module stk_ptr #(
  parameter int          PTR_W     = 8,
  parameter logic [PTR_W-1:0] RESET_PTR = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  output logic [PTR_W-1:0] ptr,
  output logic [PTR_W-1:0] ptr_up
);

  logic             ptr_en;
  logic [PTR_W-1:0] ptr_d;

  assign ptr_up = ptr + PTR_W'(1);

  always_comb begin
    ptr_en = inc | dec;
    ptr_d  = inc ? ptr_up : (ptr - PTR_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= RESET_PTR;
    end else if (ptr_en) begin
      ptr <= ptr_d;
    end
  end

endmodule

// File: rtl/stk_status_reg.sv
module stk_status_reg #(
  parameter int             W         = 8,
  parameter logic [W-1:0]   RESET_VAL = 8'h24,
  parameter logic [W-1:0]   KEEP_MASK = 8'h30
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] status,
  output logic [W-1:0] push_val
);

  logic [W-1:0] status_d;

  // bits under KEEP_MASK are forced high on push and kept on pull
  assign push_val = status | KEEP_MASK;

  always_comb begin
    status_d = (load_val & ~KEEP_MASK) | (status & KEEP_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= RESET_VAL;
    end else if (load) begin
      status <= status_d;
    end
  end

endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int WORD_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [WORD_W-1:0] cmd_data,
  input  logic [DATA_W-1:0] push_val,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              cmd_ready,
  output logic              done,
  output logic [WORD_W-1:0] rd_data,
  output logic              beat_go,
  output logic              beat_rd,
  output logic [DATA_W-1:0] wbyte,
  output logic              stat_load
);

  logic              busy_q,  busy_d;
  stk_op_e           op_q,    op_d;
  logic [WORD_W-1:0] data_q,  data_d;
  logic [1:0]        beat_q,  beat_d;
  logic              issue_q, issue_d;
  logic              pend_q,  pend_d;
  logic [1:0]        pidx_q,  pidx_d;
  logic [WORD_W-1:0] res_q,   res_d;
  logic              done_q,  done_d;

  logic accept, last_beat, stat_cap, hi_slot;

  assign cmd_ready = ~busy_q;
  assign done      = done_q;
  assign rd_data   = res_q;
  assign accept    = cmd_valid & ~busy_q;
  assign beat_go   = busy_q & issue_q;
  assign beat_rd   = op_reads(op_q);
  assign last_beat = (beat_q == (op_beats(op_q) - 2'd1));
  assign stat_cap  = ((op_q == OP_PULL_ST) || (op_q == OP_RTI)) && (pidx_q == 2'd0);
  assign hi_slot   = (op_q == OP_RTI) ? (pidx_q == 2'd2) : (pidx_q == 2'd1);
  assign stat_load = pend_q & stat_cap;

  // byte written by the current access
  always_comb begin
    case (op_q)
      OP_PUSH_B:   wbyte = data_q[DATA_W-1:0];
      OP_PUSH_W:   wbyte = (beat_q == 2'd0) ? data_q[WORD_W-1:DATA_W] : data_q[DATA_W-1:0];
      OP_PUSH_ST:  wbyte = push_val;
      OP_SAVE_CTX: begin
        case (beat_q)
          2'd0:    wbyte = data_q[WORD_W-1:DATA_W];
          2'd1:    wbyte = data_q[DATA_W-1:0];
          default: wbyte = push_val;
        endcase
      end
      default:     wbyte = '0;
    endcase
  end

  always_comb begin
    busy_d  = busy_q;
    op_d    = op_q;
    data_d  = data_q;
    beat_d  = beat_q;
    issue_d = issue_q;
    pend_d  = pend_q;
    pidx_d  = pidx_q;
    res_d   = res_q;
    done_d  = 1'b0;

    // capture read data returned for the previous access
    if (pend_q) begin
      if (!stat_cap) begin
        if (hi_slot) res_d[WORD_W-1:DATA_W] = mem_rdata;
        else         res_d[DATA_W-1:0]      = mem_rdata;
      end
      pend_d = 1'b0;
      if (!issue_q) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end

    if (beat_go) begin
      beat_d = beat_q + 2'd1;
      if (last_beat) issue_d = 1'b0;
      if (beat_rd) begin
        pend_d = 1'b1;
        pidx_d = beat_q;
      end else if (last_beat) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end

    if (accept) begin
      busy_d  = 1'b1;
      op_d    = stk_op_e'(cmd_op);
      data_d  = cmd_data;
      beat_d  = 2'd0;
      issue_d = 1'b1;
      pend_d  = 1'b0;
      res_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      op_q    <= OP_PUSH_B;
      data_q  <= '0;
      beat_q  <= '0;
      issue_q <= 1'b0;
      pend_q  <= 1'b0;
      pidx_q  <= '0;
      res_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      op_q    <= op_d;
      data_q  <= data_d;
      beat_q  <= beat_d;
      issue_q <= issue_d;
      pend_q  <= pend_d;
      pidx_q  <= pidx_d;
      res_q   <= res_d;
      done_q  <= done_d;
    end
  end

endmodule

// File: rtl/stk_stat_unit.sv
module stk_stat_unit #(
  parameter int             DATA_W       = 8,
  parameter int             WORD_W       = 2 * DATA_W,
  parameter logic [DATA_W-1:0] STACK_PAGE   = 8'h01,
  parameter logic [DATA_W-1:0] RESET_SP     = 8'hFF,
  parameter logic [DATA_W-1:0] RESET_STATUS = 8'h24,
  parameter logic [DATA_W-1:0] PHANTOM_MASK = 8'h30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [WORD_W-1:0] cmd_data,
  output logic              cmd_ready,
  output logic              done,
  output logic [WORD_W-1:0] rd_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] sp,
  output logic [DATA_W-1:0] status
);

  logic              beat_go, beat_rd, stat_load;
  logic [DATA_W-1:0] wbyte, push_val, sp_up;

  stk_seq #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_data  (cmd_data),
    .push_val  (push_val),
    .mem_rdata (mem_rdata),
    .cmd_ready (cmd_ready),
    .done      (done),
    .rd_data   (rd_data),
    .beat_go   (beat_go),
    .beat_rd   (beat_rd),
    .wbyte     (wbyte),
    .stat_load (stat_load)
  );

  stk_ptr #(.PTR_W(DATA_W), .RESET_PTR(RESET_SP)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc    (beat_go & beat_rd),
    .dec    (beat_go & ~beat_rd),
    .ptr    (sp),
    .ptr_up (sp_up)
  );

  stk_status_reg #(.W(DATA_W), .RESET_VAL(RESET_STATUS), .KEEP_MASK(PHANTOM_MASK)) u_st (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (stat_load),
    .load_val (mem_rdata),
    .status   (status),
    .push_val (push_val)
  );

  // push writes at sp, pop reads at sp+1 (pointer moves on the same edge)
  assign mem_req   = beat_go;
  assign mem_we    = beat_go & ~beat_rd;
  assign mem_addr  = {STACK_PAGE, (beat_rd ? sp_up : sp)};
  assign mem_wdata = wbyte;

endmodule

// File: rtl/stk_chk.sv
module stk_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_ready,
  input logic        done,
  input logic        mem_req,
  input logic        mem_we,
  input logic [15:0] mem_addr,
  input logic [7:0]  sp,
  input logic [7:0]  status
);

  AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[15:8] == 8'h01)); // R8

  AST_PUSH_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |=> (sp == ($past(sp) - 8'd1))); // R2

  AST_POP_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |=> (sp == ($past(sp) + 8'd1))); // R2

  AST_PHANTOM_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (status[5:4] == $past(status[5:4]))); // R5

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !mem_req); // R10

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_SP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req |=> $stable(sp)); // R10

endmodule

bind stk_stat_unit stk_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_ready (cmd_ready),
  .done      (done),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .sp        (sp),
  .status    (status)
);

// File: tb/stk_stat_unit_bench.sv
`timescale 1ns/1ps
module stk_stat_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic [15:0] cmd_data;
  logic        cmd_ready, done, mem_req, mem_we;
  logic [15:0] rd_data, mem_addr;
  logic [7:0]  mem_wdata, mem_rdata, sp, status;

  int n_vec = 0;
  int n_err = 0;

  logic [7:0] smem    [256];
  logic [7:0] ref_mem [256];
  logic [7:0] ref_sp;
  logic [7:0] ref_st;

  always #4 clk = ~clk;

  stk_stat_unit u_stk_stat_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .cmd_ready(cmd_ready), .done(done), .rd_data(rd_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .sp(sp), .status(status)
  );

  // synchronous memory model: read data valid the cycle after the request (R11)
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_addr[15:8] != 8'h01) begin
        n_err = n_err + 1;
        $display("FAIL R8 page act=%h exp=01", mem_addr[15:8]);
      end
      if (mem_we) smem[mem_addr[7:0]] <= mem_wdata;
      else        mem_rdata <= smem[mem_addr[7:0]];
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_vec = n_vec + 1;
    if (act !== exp) begin
      n_err = n_err + 1;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic void m_push(input logic [7:0] b);
    ref_mem[ref_sp] = b;
    ref_sp = ref_sp - 8'd1;
  endfunction

  function automatic logic [7:0] m_pop();
    ref_sp = ref_sp + 8'd1;
    return ref_mem[ref_sp];
  endfunction

  function automatic logic [7:0] m_merge(input logic [7:0] b);
    return (b & 8'hCF) | (ref_st & 8'h30);
  endfunction

  task automatic run(input logic [2:0] op, input logic [15:0] data, input bit junk);
    logic [15:0] exp_rd;
    logic [7:0]  lo, hi;
    int          n;
    bit          rd;
    int          cyc;
    bit          same;
    exp_rd = 16'h0000;
    rd = 1'b0;
    n = 1;
    case (op)
      3'd0: m_push(data[7:0]);
      3'd1: begin m_push(data[15:8]); m_push(data[7:0]); n = 2; end
      3'd2: begin exp_rd = {8'h00, m_pop()}; rd = 1'b1; end
      3'd3: begin lo = m_pop(); hi = m_pop(); exp_rd = {hi, lo}; rd = 1'b1; n = 2; end
      3'd4: m_push(ref_st | 8'h30);
      3'd5: begin ref_st = m_merge(m_pop()); rd = 1'b1; end
      3'd6: begin
        ref_st = m_merge(m_pop()); lo = m_pop(); hi = m_pop();
        exp_rd = {hi, lo}; rd = 1'b1; n = 3;
      end
      default: begin
        m_push(data[15:8]); m_push(data[7:0]); m_push(ref_st | 8'h30); n = 3;
      end
    endcase
    @(negedge clk);
    chk("R10 ready before cmd", {15'd0, cmd_ready}, 16'd1);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = data;
    @(negedge clk);
    cyc = 1;
    while (!done && cyc < 20) begin
      if (junk) begin
        cmd_valid = 1'b1; cmd_op = 3'($urandom); cmd_data = 16'($urandom);
      end else begin
        cmd_valid = 1'b0;
      end
      @(negedge clk);
      cyc = cyc + 1;
    end
    cmd_valid = 1'b0;
    if (!done) begin
      n_err = n_err + 1;
      $display("FAIL R9 watchdog act=no_done exp=done op=%0d", op);
    end
    chk("R9 latency", 16'(cyc), 16'(rd ? n + 2 : n + 1));
    chk("R9 ready at done", {15'd0, cmd_ready}, 16'd1);
    chk("R2 R8 sp", {8'h00, sp}, {8'h00, ref_sp});
    chk("R5 R6 status", {8'h00, status}, {8'h00, ref_st});
    if (op == 3'd2 || op == 3'd3 || op == 3'd6)
      chk("R3 R6 rd_data", rd_data, exp_rd);
    same = 1'b1;
    for (int i = 0; i < 256; i++) if (smem[i] !== ref_mem[i]) same = 1'b0;
    chk("R3 R4 R7 stack memory", {15'd0, same}, 16'd1);
    @(negedge clk);
    chk("R9 done single", {15'd0, done}, 16'd0);
  endtask

  initial begin
    void'($urandom(32'd5150));
    for (int i = 0; i < 256; i++) begin
      smem[i] = 8'($urandom);
      ref_mem[i] = smem[i];
    end
    mem_rdata = 8'h00;
    cmd_valid = 1'b0; cmd_op = 3'd0; cmd_data = 16'h0000;
    rst_n = 1'b0;
    ref_sp = 8'hFF; ref_st = 8'h24;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sp", {8'h00, sp}, 16'h00FF);
    chk("R1 status", {8'h00, status}, 16'h0024);
    chk("R1 ready", {15'd0, cmd_ready}, 16'd1);
    chk("R1 done", {15'd0, done}, 16'd0);
    chk("R1 mem_req", {15'd0, mem_req}, 16'd0);

    // R8 wrap: pop from 0xFF reads 0x0100, push from 0x00 back to 0xFF
    run(3'd2, 16'h0000, 1'b0);
    run(3'd0, 16'h00A5, 1'b0);
    // R5 phantom bits kept from register (0x24 -> bits 5..4 = 10)
    run(3'd0, 16'h00FF, 1'b0);
    run(3'd5, 16'h0000, 1'b0);
    run(3'd0, 16'h0000, 1'b0);
    run(3'd5, 16'h0000, 1'b0);
    // R4 status push forces bits 5..4
    run(3'd4, 16'h0000, 1'b0);
    // R3 word order, R7 context save then R6 return
    run(3'd1, 16'h1234, 1'b0);
    run(3'd3, 16'h0000, 1'b0);
    run(3'd7, 16'hBEEF, 1'b1);
    run(3'd6, 16'h0000, 1'b1);
    // R10 junk commands while busy, random mix
    for (int k = 0; k < 400; k++)
      run(3'($urandom), 16'($urandom), 1'($urandom));

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    #2000000;
    n_err = n_err + 1;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

endmodule